// File: doc/BRIEF.md
# Macro-Fusion Decode Group Former

This block sits between an instruction pre-decoder and the instruction decode queue. Each cycle it looks at a window of up to six pre-decoded descriptors, oldest first, and forms one decode group. Each descriptor carries a class, a uop count and a memory-operand flag. When a flag-setting ALU op is followed directly by a conditional branch, the two can be merged into one fused uop. The block reports how many descriptors it consumed, so the upstream window can shift by that amount. It drives up to five fused-domain uops toward the queue.

A group is bounded by four decode slots, where a fused pair occupies a single slot, and by five uops. A mode input chooses between two policies. Under the legacy policy at most one fusion is made per group, and a fusable op in the last slot is held back. Under the dual policy up to two fusions are made, and the group closes immediately after the second. Free-running counters track the consumed instructions, the emitted uops, the fusions made and the cycles in which at least one uop was emitted.

Top module: `fusion_group_former`

## Requirements
- R1: A group uses at most 4 decode slots (a fused pair takes one slot) and emits at most 5 uops. Uops fill `uop_vld` from bit 0 upward with no gaps. `uop_pos` holds, 3 bits per uop, the window position of the instruction that produced the uop.
- R2: The uop count field is 3 bits with legal values 1 to 4. Only the first instruction of a group may have a count above 1. A multi-uop instruction at any later position ends the group just before it. Patterns such as 4-1 and 2-1-1-1 are accepted.
- R3: Class field encoding is 0 = other, 1 = fusable ALU op, 2 = conditional branch, 3 = other. A single-uop class-1 instruction directly followed by a class-2 instruction becomes one uop with `uop_fused` set. That uop counts as two consumed instructions.
- R4: With `dual_mode`=1, a group holds at most two fusions, and it closes right after the second fusion even if more instructions would fit.
- R5: With `dual_mode`=0, a group holds at most one fusion. A later ALU/branch pair in the same group is emitted as two unfused uops.
- R6: With `dual_mode`=0, if the last instruction taken into a group of two or more slots is an unfused fusable ALU op, it is left for the next cycle.
- R7: With `mem_fuse_block`=1, a class-1 op whose memory flag is set is not fusable and is emitted unfused. With `mem_fuse_block`=0 the memory flag has no effect on fusion.
- R8: A group is emitted only when `idq_free` is at least its uop count. Otherwise `take` is 0 and no uop is valid.
- R9: Each cycle the counters add, respectively, `take`, the number of valid uops, the number of fused uops, and one if any uop is valid.
- R10: After reset all counters read 0. With an empty window, `take` and `uop_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dual_mode | input | 1 | 1 = dual-fusion policy, 0 = legacy policy |
| mem_fuse_block | input | 1 | Forbid fusion of ALU ops with a memory operand |
| in_vld | input | W | Valid bits of the window, a prefix from position 0 |
| in_cls | input | 2*W | Class per position |
| in_ucnt | input | 3*W | Uop count per position |
| in_mem | input | W | Memory-operand flag per position |
| idq_free | input | 3 | Free entries in the decode queue |
| take | output | 3 | Descriptors consumed this cycle |
| uop_vld | output | 5 | Valid bit per emitted uop |
| uop_fused | output | 5 | Fused flag per emitted uop |
| uop_pos | output | 15 | Source window position per uop |
| cnt_inst | output | CW | Instructions consumed |
| cnt_uops | output | CW | Uops emitted |
| cnt_fus | output | CW | Fusions made |
| cnt_active | output | CW | Cycles with at least one uop emitted |

## Verification
The assertions assume that the valid bits form a prefix from position 0, that every uop count lies between 1 and 4, and that the window only changes between clock edges. The bench applies each window at the falling edge. It builds every window from position 0 upward with legal counts, and it clears the window during reset, so the counter properties start from a clean state.

// File: rtl/fusion_group_former.sv
module fusion_group_former #(
  parameter int W  = 6,
  parameter int CW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dual_mode,
  input  logic            mem_fuse_block,
  input  logic [W-1:0]    in_vld,
  input  logic [2*W-1:0]  in_cls,
  input  logic [3*W-1:0]  in_ucnt,
  input  logic [W-1:0]    in_mem,
  input  logic [2:0]      idq_free,
  output logic [2:0]      take,
  output logic [4:0]      uop_vld,
  output logic [4:0]      uop_fused,
  output logic [14:0]     uop_pos,
  output logic [CW-1:0]   cnt_inst,
  output logic [CW-1:0]   cnt_uops,
  output logic [CW-1:0]   cnt_fus,
  output logic [CW-1:0]   cnt_active
);
  localparam int SLOTS = 4;
  localparam int MAXU  = 5;
  localparam int PW    = 3;
  localparam logic [1:0] C_ALU = 2'd1;
  localparam logic [1:0] C_BR  = 2'd2;

  logic [W-1:0]   nxt_vld;
  logic [2*W-1:0] nxt_cls;
  assign nxt_vld = {1'b0, in_vld[W-1:1]};
  assign nxt_cls = {2'b00, in_cls[2*W-1:2]};

  logic [3:0] nu, u, cost, idx;
  logic [2:0] ns, tk;
  logic [1:0] nf, lim;
  logic       stop, skip, lastfus, fus, pair;
  logic [4:0] gv, gf;
  logic [14:0] gp;

  assign lim = dual_mode ? 2'd2 : 2'd1;

  always_comb begin
    nu = '0; ns = '0; nf = '0; tk = '0;
    stop = 1'b0; skip = 1'b0; lastfus = 1'b0;
    u = '0; cost = '0; idx = '0; fus = 1'b0; pair = 1'b0;
    gv = '0; gf = '0; gp = '0;
    for (int p = 0; p < W; p++) begin
      if (skip) begin
        skip = 1'b0;
      end else if (!stop) begin
        if (!in_vld[p] || ns == 3'(SLOTS)) begin
          stop = 1'b1;
        end else begin
          u    = {1'b0, in_ucnt[3*p +: 3]};
          fus  = (in_cls[2*p +: 2] == C_ALU) && (u == 4'd1) && !(in_mem[p] && mem_fuse_block);
          pair = fus && nxt_vld[p] && (nxt_cls[2*p +: 2] == C_BR) && (nf < lim);
          cost = pair ? 4'd1 : u;
          if ((p > 0 && !pair && u > 4'd1) || (nu + cost > 4'(MAXU))) begin
            stop = 1'b1;
          end else begin
            for (int k = 0; k < 4; k++) begin
              idx = nu + 4'(k);
              if (4'(k) < cost && idx < 4'(MAXU)) begin
                gv[idx[2:0]] = 1'b1;
                gf[idx[2:0]] = pair;
                gp[PW*idx[2:0] +: PW] = PW'(p);
              end
            end
            nu      = nu + cost;
            ns      = ns + 3'd1;
            tk      = tk + (pair ? 3'd2 : 3'd1);
            nf      = nf + {1'b0, pair};
            skip    = pair;
            lastfus = fus && !pair;
            if (pair && dual_mode && nf == 2'd2) stop = 1'b1;
          end
        end
      end
    end
    if (!dual_mode && lastfus && ns >= 3'd2) begin
      tk = tk - 3'd1;
      ns = ns - 3'd1;
      nu = nu - 4'd1;
      gv[nu[2:0]] = 1'b0;
      gf[nu[2:0]] = 1'b0;
      gp[PW*nu[2:0] +: PW] = '0;
    end
  end

  logic go;
  assign go        = in_vld[0] && (nu <= {1'b0, idq_free});
  assign take      = go ? tk : '0;
  assign uop_vld   = go ? gv : '0;
  assign uop_fused = go ? gf : '0;
  assign uop_pos   = go ? gp : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_inst   <= '0;
      cnt_uops   <= '0;
      cnt_fus    <= '0;
      cnt_active <= '0;
    end else begin
      cnt_inst   <= cnt_inst + CW'(take);
      cnt_uops   <= cnt_uops + CW'($countones(uop_vld));
      cnt_fus    <= cnt_fus + CW'($countones(uop_fused));
      cnt_active <= cnt_active + CW'(|uop_vld);
    end
  end
endmodule

// File: rtl/fusion_group_former_chk.sv
module fusion_group_former_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dual_mode,
  input logic [2:0]    idq_free,
  input logic [2:0]    take,
  input logic [4:0]    uop_vld,
  input logic [4:0]    uop_fused,
  input logic [CW-1:0] cnt_inst,
  input logic [CW-1:0] cnt_uops
);
  AST_UOP_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    ((uop_vld & (uop_vld + 5'd1)) == 5'd0)); // R1
  AST_FUSED_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ((uop_fused & ~uop_vld) == 5'd0)); // R3
  AST_DUAL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(uop_fused) <= 2)); // R4
  AST_LEGACY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |-> ($countones(uop_fused) <= 1)); // R5
  AST_QUEUE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(uop_vld) <= 32'(idq_free))); // R8
  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_vld == 5'd0) |-> (take == 3'd0)); // R8
  AST_UOP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_uops == $past(cnt_uops) + CW'($countones($past(uop_vld))))); // R9
  AST_INST_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_inst == $past(cnt_inst) + CW'($past(take)))); // R9
endmodule

bind fusion_group_former fusion_group_former_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .idq_free(idq_free),
  .take(take), .uop_vld(uop_vld), .uop_fused(uop_fused),
  .cnt_inst(cnt_inst), .cnt_uops(cnt_uops)
);

// File: tb/fusion_group_former_bench.sv
module fusion_group_former_bench;
  localparam int CLK_P = 10;
  localparam int W = 6;
  localparam int CW = 32;
  localparam logic [1:0] OT = 2'd0, AL = 2'd1, BR = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0, dual_mode = 1'b1, mem_fuse_block = 1'b0;
  logic [W-1:0] in_vld = '0, in_mem = '0;
  logic [2*W-1:0] in_cls = '0;
  logic [3*W-1:0] in_ucnt = '0;
  logic [2:0] idq_free = 3'd5;
  logic [2:0] take;
  logic [4:0] uop_vld, uop_fused;
  logic [14:0] uop_pos;
  logic [CW-1:0] cnt_inst, cnt_uops, cnt_fus, cnt_active;

  int checks = 0, errors = 0;
  int e_inst = 0, e_uops = 0, e_fus = 0, e_act = 0;

  always #(CLK_P/2) clk = ~clk;

  fusion_group_former #(.W(W), .CW(CW)) u_fusion_group_former (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clear_win();
    in_vld = '0; in_cls = '0; in_ucnt = '0; in_mem = '0;
    idq_free = 3'd5; mem_fuse_block = 1'b0; dual_mode = 1'b1;
  endtask

  task automatic put(int p, logic [1:0] c, logic [2:0] n, logic m);
    in_vld[p] = 1'b1; in_cls[2*p +: 2] = c; in_ucnt[3*p +: 3] = n; in_mem[p] = m;
  endtask

  task automatic expect_group(string req, logic [2:0] et, logic [4:0] ev, logic [4:0] ef);
    #1;
    chk({req, " take"}, 32'(take), 32'(et));
    chk({req, " uop_vld"}, 32'(uop_vld), 32'(ev));
    chk({req, " uop_fused"}, 32'(uop_fused), 32'(ef));
    e_inst += et; e_uops += $countones(ev); e_fus += $countones(ef); e_act += (ev != 0);
  endtask

  task automatic t_reset();
    chk("R10 cnt_inst", cnt_inst, 0);
    chk("R10 cnt_uops", cnt_uops, 0);
    chk("R10 cnt_fus", cnt_fus, 0);
    chk("R10 cnt_active", cnt_active, 0);
    @(negedge clk); clear_win();
    expect_group("R10 empty", 3'd0, 5'b00000, 5'b00000);
  endtask

  task automatic t_limits();
    @(negedge clk); clear_win();
    for (int p = 0; p < 5; p++) put(p, OT, 3'd1, 1'b0);
    expect_group("R1 slot cap", 3'd4, 5'b01111, 5'b00000);
    @(negedge clk); clear_win();
    put(0, OT, 3'd4, 1'b0); put(1, OT, 3'd1, 1'b0); put(2, OT, 3'd1, 1'b0);
    expect_group("R1 4-1", 3'd2, 5'b11111, 5'b00000);
    chk("R1 uop_pos 4-1", 32'(uop_pos), 32'(15'd1 << 12));
  endtask

  task automatic t_multi();
    @(negedge clk); clear_win();
    put(0, OT, 3'd2, 1'b0);
    for (int p = 1; p < 4; p++) put(p, OT, 3'd1, 1'b0);
    expect_group("R2 2-1-1-1", 3'd4, 5'b11111, 5'b00000);
    @(negedge clk); clear_win();
    put(0, OT, 3'd1, 1'b0); put(1, OT, 3'd2, 1'b0); put(2, OT, 3'd1, 1'b0);
    expect_group("R2 late multi", 3'd1, 5'b00001, 5'b00000);
  endtask

  task automatic t_dual();
    @(negedge clk); clear_win();
    put(0, AL, 3'd1, 1'b0); put(1, BR, 3'd1, 1'b0);
    put(2, AL, 3'd1, 1'b0); put(3, BR, 3'd1, 1'b0); put(4, OT, 3'd1, 1'b0);
    expect_group("R3 R4 two fusions stop", 3'd4, 5'b00011, 5'b00011);
    chk("R3 uop_pos pairs", 32'(uop_pos), 32'(15'd16));
    @(negedge clk); clear_win();
    put(0, OT, 3'd1, 1'b0); put(1, AL, 3'd1, 1'b0); put(2, BR, 3'd1, 1'b0);
    put(3, OT, 3'd1, 1'b0); put(4, AL, 3'd1, 1'b0); put(5, BR, 3'd1, 1'b0);
    expect_group("R4 interleaved", 3'd6, 5'b01111, 5'b01010);
  endtask

  task automatic t_legacy();
    @(negedge clk); clear_win(); dual_mode = 1'b0;
    put(0, AL, 3'd1, 1'b0); put(1, BR, 3'd1, 1'b0);
    put(2, AL, 3'd1, 1'b0); put(3, BR, 3'd1, 1'b0); put(4, OT, 3'd1, 1'b0);
    expect_group("R5 one fusion", 3'd5, 5'b01111, 5'b00001);
    @(negedge clk); clear_win(); dual_mode = 1'b0;
    for (int p = 0; p < 3; p++) put(p, OT, 3'd1, 1'b0);
    put(3, AL, 3'd1, 1'b0);
    expect_group("R6 hold back", 3'd3, 5'b00111, 5'b00000);
    @(negedge clk); clear_win();
    for (int p = 0; p < 3; p++) put(p, OT, 3'd1, 1'b0);
    put(3, AL, 3'd1, 1'b0);
    expect_group("R6 dual no hold", 3'd4, 5'b01111, 5'b00000);
  endtask

  task automatic t_mem();
    @(negedge clk); clear_win(); mem_fuse_block = 1'b1;
    put(0, AL, 3'd1, 1'b1); put(1, BR, 3'd1, 1'b0);
    expect_group("R7 mem blocked", 3'd2, 5'b00011, 5'b00000);
    @(negedge clk); clear_win();
    put(0, AL, 3'd1, 1'b1); put(1, BR, 3'd1, 1'b0);
    expect_group("R7 mem allowed", 3'd2, 5'b00001, 5'b00001);
  endtask

  task automatic t_backpressure();
    @(negedge clk); clear_win(); idq_free = 3'd2;
    put(0, AL, 3'd1, 1'b0); put(1, BR, 3'd1, 1'b0);
    put(2, OT, 3'd1, 1'b0); put(3, OT, 3'd1, 1'b0);
    expect_group("R8 stall", 3'd0, 5'b00000, 5'b00000);
    @(negedge clk); idq_free = 3'd3;
    expect_group("R8 exact room", 3'd4, 5'b00111, 5'b00001);
  endtask

  task automatic t_counters();
    @(negedge clk); clear_win();
    @(negedge clk);
    chk("R9 cnt_inst", cnt_inst, e_inst);
    chk("R9 cnt_uops", cnt_uops, e_uops);
    chk("R9 cnt_fus", cnt_fus, e_fus);
    chk("R9 cnt_active", cnt_active, e_act);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_limits();
    t_multi();
    t_dual();
    t_legacy();
    t_mem();
    t_backpressure();
    t_counters();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule